// File: doc/BRIEF.md
# Reference clock supervisor with failover and divider-ratio selection

This block is the digital supervisor that sits beside a clock-multiplying PLL. It takes two edge-strobe inputs, one from the primary clock and one from the backup reference. Each strobe has already been pre-divided and brought into the timebase domain. Each input's edges are counted over a fixed gate window of the timebase, and the count places the input in one of six octave bands or marks it out of band. An input becomes valid after a run of good windows and fails after a short run of bad ones. The block then chooses which input feeds the PLL and sets the PLL's feedback ratio so that the output frequency stays the same whichever input is in use.

When the primary fails, the block first asserts the PLL hold command, which freezes the VCO control at its last value. It then moves the input select to the backup and loads the ratio for the backup's band. When the primary requalifies, the block returns to it through the same hold-protected sequence and waits out an acquisition interval before it reports lock. The active-low lock flag is low only while the loop is locked to a primary input that is within tolerance. A static mode input picks one of two output ranges. An active-low power-down input clears everything.

Top module: `refFailoverMon`

## Requirements
- R1: Over one window of GATE_CYCLES timebase cycles, a count N is in band k (k = 0..5) when BAND_LO·2^k ≤ N ≤ BAND_HI·2^k. Any other count, including zero, is a bad window. With the defaults the bands are 10–14, 20–28, 40–56, 80–112, 160–224 and 320–448.
- R2: `pllRatioLog2` is a 4-bit two's complement base-2 logarithm of the output/input ratio. It is 3−k for band k when `modeHigh` is 0, giving ratios 8 down to 1/4, and 5−k when `modeHigh` is 1, giving ratios 32 down to 1.
- R3: `lockN` is 0 only when `pllSelBak` is 0 (the primary is selected), acquisition is complete, `pllHold` is 0 and the primary is within its drift tolerance. In every other condition `lockN` is 1.
- R4: When the primary fails and the backup is valid, the block asserts `pllHold`. It then sets `pllSelBak` to 1 and loads the ratio of the backup's band, so that `lockN` stays 1 while the backup is in use.
- R5: When a valid primary returns, the block switches back to it (`pllSelBak` = 0), loads the ratio of the primary's band, and drives `lockN` low ACQ_CYCLES cycles after hold is released.
- R6: If the primary's count in band k lies outside BAND_NOM·2^k ± DRIFT_TOL·2^k, `lockN` goes to 1 while the selection stays on the primary. `lockN` returns to 0 once the count is back within tolerance.
- R7: While `pdN` is 0, all state is cleared: `lockN` = 1, `outEn` = 0, `pllHold` = 1, `pllSelBak` = 0 and `pllRatioLog2` = 0.
- R8: A change of `modeHigh` after power-up restarts acquisition. `lockN` goes to 1 on the next cycle and stays there until the block has reacquired with the ratio for the new mode.
- R9: An input fails only after FAIL_WIN (2) consecutive bad windows. It becomes valid only after VALID_WIN (4) consecutive in-band windows.
- R10: `pllSelBak` and `pllRatioLog2` change only in a cycle where `pllHold` is 1 in both that cycle and the one before it. Hold is released at the window boundary that closes a full window after the change.
- R11: When both inputs are invalid, `pllHold` = 1 and `lockN` = 1, and the last ratio is kept. The first input to qualify is then selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tbClk | input | 1 | Timebase clock that defines the gate window |
| pdN | input | 1 | Active-low power-down; clears all state asynchronously |
| modeHigh | input | 1 | Static output-range select: 0 for the low range, 1 for the high range |
| priEdge | input | 1 | One-cycle strobe per pre-divided primary clock edge |
| bakEdge | input | 1 | One-cycle strobe per pre-divided backup clock edge |
| outEn | output | 1 | Output driver enable; 0 during power-down |
| lockN | output | 1 | Low only when locked to an in-tolerance primary |
| pllHold | output | 1 | Freezes the PLL's VCO control |
| pllSelBak | output | 1 | PLL input select: 0 for the primary, 1 for the backup |
| pllRatioLog2 | output | 4 | Signed base-2 logarithm of the output/input ratio |

## Verification
The bench sweeps all six bands in both modes from power-up. In each case it checks the selected ratio and that lock is reached; a design that got the ratio arithmetic or a band boundary wrong would show a wrong ratio, or would never lock. It stops the primary and checks that the selection holds for one window, which catches a design that fails an input after a single bad window. It also checks that the block does not switch back within three windows of the primary's return, which catches one that qualifies too early. Further cases cover an off-nominal but in-band primary, which must raise lock without a failover, and a count that falls in the gap between two bands, which must cause a failover. The last cases are the loss of both inputs, which must keep the ratio in holdover, and a mode flip, which must reload the ratio. Throughout the run a monitor flags any change of select or ratio that is not covered by hold, which is how a glitching switchover would show.

// File: rtl/refMonPkg.sv
package refMonPkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_SWITCH,
    ST_ACQ,
    ST_LOCK,
    ST_BAK
  } monState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hold;
    logic load;
    logic loadBak;
    logic acqRun;
  } monCtl_t;

  // log2 of output/input ratio for a band in a mode
  function automatic logic signed [3:0] ratioLog2(input logic modeHigh,
                                                  input logic [2:0] band);
    logic signed [3:0] top;
    top = modeHigh ? 4'sd5 : 4'sd3;
    return top - $signed({1'b0, band});
  endfunction

endpackage

// File: rtl/bandMonitor.sv
module bandMonitor #(
  parameter int GATE_CYCLES = 512,
  parameter int BAND_LO     = 10,
  parameter int BAND_NOM    = 12,
  parameter int BAND_HI     = 14,
  parameter int DRIFT_TOL   = 1,
  parameter int VALID_WIN   = 4,
  parameter int FAIL_WIN    = 2,
  parameter int NUM_BANDS   = 6
) (
  input  logic       clk,
  input  logic       pdN,
  input  logic       edgeIn,
  input  logic       winEnd,
  output logic       valid,
  output logic [2:0] band,
  output logic       drift
);
  localparam int CNT_W  = $clog2(GATE_CYCLES + 1);
  localparam int GOOD_W = $clog2(VALID_WIN + 1);
  localparam int BAD_W  = $clog2(FAIL_WIN + 1);

  logic [CNT_W-1:0]     edgeCnt;
  logic [CNT_W-1:0]     total;
  logic [NUM_BANDS-1:0] hit;
  logic [NUM_BANDS-1:0] off;
  logic [GOOD_W-1:0]    goodCnt;
  logic [BAD_W-1:0]     badCnt;
  logic                 hitAny;
  logic [2:0]           hitBand;
  logic                 hitDrift;

  assign total = edgeCnt + CNT_W'(edgeIn);

  for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
    localparam int LoK  = BAND_LO << k;
    localparam int HiK  = BAND_HI << k;
    localparam int NomK = BAND_NOM << k;
    localparam int TolK = DRIFT_TOL << k;
    assign hit[k] = (total >= CNT_W'(LoK)) && (total <= CNT_W'(HiK));
    assign off[k] = (total < CNT_W'(NomK - TolK)) || (total > CNT_W'(NomK + TolK));
  end

  always_comb begin
    hitAny   = |hit;
    hitBand  = '0;
    hitDrift = 1'b0;
    for (int k = 0; k < NUM_BANDS; k++) begin
      if (hit[k]) begin
        hitBand  = 3'(k);
        hitDrift = off[k];
      end
    end
  end

  always_ff @(posedge clk or negedge pdN) begin
    if (!pdN) begin
      edgeCnt <= '0;
      goodCnt <= '0;
      badCnt  <= '0;
      valid   <= 1'b0;
      band    <= '0;
      drift   <= 1'b0;
    end else if (winEnd) begin
      edgeCnt <= '0;
      if (hitAny) begin
        badCnt <= '0;
        band   <= hitBand;
        drift  <= hitDrift;
        if (goodCnt != GOOD_W'(VALID_WIN)) goodCnt <= goodCnt + 1'b1;
        if (goodCnt == GOOD_W'(VALID_WIN - 1)) valid <= 1'b1;
      end else begin
        goodCnt <= '0;
        drift   <= 1'b0;
        if (badCnt != BAD_W'(FAIL_WIN)) badCnt <= badCnt + 1'b1;
        if (badCnt == BAD_W'(FAIL_WIN - 1)) valid <= 1'b0;
      end
    end else if (edgeIn) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  // R9: qualification state only moves at a window boundary
  a_r9_valid_moves_at_window: assert property (@(posedge clk) disable iff (!pdN)
    !$stable(valid) |-> $past(winEnd));

  // R1: the band index stays within the band table
  a_r1_band_in_range: assert property (@(posedge clk) disable iff (!pdN)
    band < 3'(NUM_BANDS));

endmodule

// File: rtl/refMonDatapath.sv
module refMonDatapath
  import refMonPkg::*;
#(
  parameter int GATE_CYCLES = 512,
  parameter int BAND_LO     = 10,
  parameter int BAND_NOM    = 12,
  parameter int BAND_HI     = 14,
  parameter int DRIFT_TOL   = 1,
  parameter int VALID_WIN   = 4,
  parameter int FAIL_WIN    = 2,
  parameter int ACQ_CYCLES  = 300
) (
  input  logic              clk,
  input  logic              pdN,
  input  logic              modeHigh,
  input  logic              priEdge,
  input  logic              bakEdge,
  input  monCtl_t           ctl,
  output logic              winEnd,
  output logic              priValid,
  output logic              bakValid,
  output logic              priDrift,
  output logic              acqDone,
  output logic              selBak,
  output logic signed [3:0] ratio
);
  localparam int WIN_W = $clog2(GATE_CYCLES);
  localparam int ACQ_W = $clog2(ACQ_CYCLES + 1);

  logic [WIN_W-1:0] winCnt;
  logic [ACQ_W-1:0] acqCnt;
  logic [2:0]       priBand;
  logic [2:0]       bakBand;
  logic             bakDrift;

  assign winEnd  = (winCnt == WIN_W'(GATE_CYCLES - 1));
  assign acqDone = (acqCnt == ACQ_W'(ACQ_CYCLES));

  always_ff @(posedge clk or negedge pdN) begin
    if (!pdN) winCnt <= '0;
    else      winCnt <= winEnd ? '0 : winCnt + 1'b1;
  end

  bandMonitor #(
    .GATE_CYCLES(GATE_CYCLES), .BAND_LO(BAND_LO), .BAND_NOM(BAND_NOM),
    .BAND_HI(BAND_HI), .DRIFT_TOL(DRIFT_TOL), .VALID_WIN(VALID_WIN),
    .FAIL_WIN(FAIL_WIN)
  ) uPriMon (
    .clk(clk), .pdN(pdN), .edgeIn(priEdge), .winEnd(winEnd),
    .valid(priValid), .band(priBand), .drift(priDrift)
  );

  bandMonitor #(
    .GATE_CYCLES(GATE_CYCLES), .BAND_LO(BAND_LO), .BAND_NOM(BAND_NOM),
    .BAND_HI(BAND_HI), .DRIFT_TOL(DRIFT_TOL), .VALID_WIN(VALID_WIN),
    .FAIL_WIN(FAIL_WIN)
  ) uBakMon (
    .clk(clk), .pdN(pdN), .edgeIn(bakEdge), .winEnd(winEnd),
    .valid(bakValid), .band(bakBand), .drift(bakDrift)
  );

  always_ff @(posedge clk or negedge pdN) begin
    if (!pdN)                 acqCnt <= '0;
    else if (!ctl.acqRun)     acqCnt <= '0;
    else if (!acqDone)        acqCnt <= acqCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge pdN) begin
    if (!pdN) begin
      selBak <= 1'b0;
      ratio  <= '0;
    end else if (ctl.load) begin
      selBak <= ctl.loadBak;
      ratio  <= ratioLog2(modeHigh, ctl.loadBak ? bakBand : priBand);
    end
  end

  // R10: select moves only under a hold that was already up
  a_r10_sel_under_hold: assert property (@(posedge clk) disable iff (!pdN)
    !$stable(selBak) |-> (ctl.hold && $past(ctl.hold)));

  // R10: ratio moves only under a hold that was already up
  a_r10_ratio_under_hold: assert property (@(posedge clk) disable iff (!pdN)
    !$stable(ratio) |-> (ctl.hold && $past(ctl.hold)));

endmodule

// File: rtl/refMonControl.sv
module refMonControl
  import refMonPkg::*;
(
  input  logic    clk,
  input  logic    pdN,
  input  logic    modeHigh,
  input  logic    winEnd,
  input  logic    priValid,
  input  logic    bakValid,
  input  logic    priDrift,
  input  logic    acqDone,
  output monCtl_t ctl,
  output logic    lockN,
  output logic    outEn
);
  monState_e state, stateNext;
  logic tgtBak, tgtBakNext;
  logic swArm;
  logic modeQ, modeSeen, modeChg;

  assign modeChg = modeSeen && (modeHigh != modeQ);

  always_comb begin
    stateNext   = state;
    tgtBakNext  = tgtBak;
    ctl         = '0;
    ctl.hold    = (state == ST_HOLD) || (state == ST_SWITCH);
    ctl.acqRun  = (state == ST_ACQ);
    unique case (state)
      ST_HOLD: begin
        if (!modeChg && (priValid || bakValid)) begin
          stateNext   = ST_SWITCH;
          tgtBakNext  = !priValid;
          ctl.load    = 1'b1;
          ctl.loadBak = !priValid;
        end
      end
      ST_SWITCH: begin
        if (modeChg) stateNext = ST_HOLD;
        else if (winEnd && swArm) begin
          if (tgtBak) stateNext = bakValid ? ST_BAK : ST_HOLD;
          else        stateNext = priValid ? ST_ACQ : ST_HOLD;
        end
      end
      ST_ACQ: begin
        if (modeChg || !priValid) stateNext = ST_HOLD;
        else if (acqDone)         stateNext = ST_LOCK;
      end
      ST_LOCK: begin
        if (modeChg || !priValid) stateNext = ST_HOLD;
      end
      ST_BAK: begin
        if (modeChg || priValid || !bakValid) stateNext = ST_HOLD;
      end
      default: stateNext = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge pdN) begin
    if (!pdN) begin
      state    <= ST_HOLD;
      tgtBak   <= 1'b0;
      swArm    <= 1'b0;
      modeQ    <= 1'b0;
      modeSeen <= 1'b0;
      outEn    <= 1'b0;
    end else begin
      state    <= stateNext;
      tgtBak   <= tgtBakNext;
      modeQ    <= modeHigh;
      modeSeen <= 1'b1;
      outEn    <= 1'b1;
      if (state != ST_SWITCH) swArm <= 1'b0;
      else if (winEnd)        swArm <= 1'b1;
    end
  end

  assign lockN = !((state == ST_LOCK) && !priDrift);

  // R8: a mode flip drops lock on the following cycle
  a_r8_mode_restart: assert property (@(posedge clk) disable iff (!pdN)
    modeChg |=> lockN);

  // R11: with neither input valid, lock is never reported
  a_r11_no_lock_without_input: assert property (@(posedge clk) disable iff (!pdN)
    (!priValid && !bakValid) |=> lockN);

endmodule

// File: rtl/refFailoverMon.sv
module refFailoverMon
  import refMonPkg::*;
#(
  parameter int GATE_CYCLES = 512,
  parameter int BAND_LO     = 10,
  parameter int BAND_NOM    = 12,
  parameter int BAND_HI     = 14,
  parameter int DRIFT_TOL   = 1,
  parameter int VALID_WIN   = 4,
  parameter int FAIL_WIN    = 2,
  parameter int ACQ_CYCLES  = 300
) (
  input  logic       tbClk,
  input  logic       pdN,
  input  logic       modeHigh,
  input  logic       priEdge,
  input  logic       bakEdge,
  output logic       outEn,
  output logic       lockN,
  output logic       pllHold,
  output logic       pllSelBak,
  output logic [3:0] pllRatioLog2
);
  monCtl_t           ctl;
  logic              winEnd, priValid, bakValid, priDrift, acqDone;
  logic signed [3:0] ratio;

  refMonDatapath #(
    .GATE_CYCLES(GATE_CYCLES), .BAND_LO(BAND_LO), .BAND_NOM(BAND_NOM),
    .BAND_HI(BAND_HI), .DRIFT_TOL(DRIFT_TOL), .VALID_WIN(VALID_WIN),
    .FAIL_WIN(FAIL_WIN), .ACQ_CYCLES(ACQ_CYCLES)
  ) uDp (
    .clk(tbClk), .pdN(pdN), .modeHigh(modeHigh), .priEdge(priEdge),
    .bakEdge(bakEdge), .ctl(ctl), .winEnd(winEnd), .priValid(priValid),
    .bakValid(bakValid), .priDrift(priDrift), .acqDone(acqDone),
    .selBak(pllSelBak), .ratio(ratio)
  );

  refMonControl uCtl (
    .clk(tbClk), .pdN(pdN), .modeHigh(modeHigh), .winEnd(winEnd),
    .priValid(priValid), .bakValid(bakValid), .priDrift(priDrift),
    .acqDone(acqDone), .ctl(ctl), .lockN(lockN), .outEn(outEn)
  );

  assign pllHold      = ctl.hold;
  assign pllRatioLog2 = ratio;

  // R3: reported lock implies primary selected and loop running free
  a_r3_lock_on_primary: assert property (@(posedge tbClk) disable iff (!pdN)
    !lockN |-> (!pllSelBak && !pllHold));

  // R7: power-down keeps outputs quiet
  a_r7_pd_quiet: assert property (@(posedge tbClk)
    !pdN |-> (lockN && !outEn && pllHold && !pllSelBak));

endmodule

// File: tb/tb_refFailoverMon.sv
module tb_refFailoverMon;
  localparam int CLK_PERIOD = 10;
  localparam int GATE       = 512;
  localparam int NOMC       = 12;

  logic tbClk = 1'b0;
  logic pdN = 1'b0;
  logic modeHigh = 1'b0;
  logic priEdge = 1'b0;
  logic bakEdge = 1'b0;
  logic outEn, lockN, pllHold, pllSelBak;
  logic [3:0] pllRatioLog2;

  int ratePri = 0, rateBak = 0;
  int accPri = 0, accBak = 0;
  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic prevSel = 1'b0, prevHold = 1'b1, prevPd = 1'b0;

  refFailoverMon dut (
    .tbClk(tbClk), .pdN(pdN), .modeHigh(modeHigh), .priEdge(priEdge),
    .bakEdge(bakEdge), .outEn(outEn), .lockN(lockN), .pllHold(pllHold),
    .pllSelBak(pllSelBak), .pllRatioLog2(pllRatioLog2)
  );

  always #(CLK_PERIOD/2) tbClk = ~tbClk;

  // edge strobes: exactly rate edges in any GATE consecutive cycles
  always @(negedge tbClk) begin
    accPri = accPri + ratePri;
    if (accPri >= GATE) begin accPri = accPri - GATE; priEdge = 1'b1; end
    else priEdge = 1'b0;
    accBak = accBak + rateBak;
    if (accBak >= GATE) begin accBak = accBak - GATE; bakEdge = 1'b1; end
    else bakEdge = 1'b0;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R10 monitor: select or ratio change must sit under hold
  logic [3:0] prevRatio = 4'd0;
  always @(negedge tbClk) begin
    if (pdN && prevPd && (pllSelBak !== prevSel || pllRatioLog2 !== prevRatio))
      check(pllHold && prevHold, "R10 change without hold", int'(pllHold), 1);
    prevSel = pllSelBak; prevHold = pllHold; prevPd = pdN; prevRatio = pllRatioLog2;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge tbClk);
  endtask

  task automatic waitLock(input int maxc, output bit got);
    got = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge tbClk);
      if (lockN == 1'b0) begin got = 1; break; end
    end
  endtask

  task automatic waitSel(input logic v, input int maxc, output bit got);
    got = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge tbClk);
      if (pllSelBak == v && !pllHold) begin got = 1; break; end
    end
  endtask

  function automatic int expRatio(input bit m, input int b);
    return (m ? 5 : 3) - b;
  endfunction

  function automatic int ratioNow();
    return int'($signed(pllRatioLog2));
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge tbClk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
    end
  end

  initial begin
    bit got;
    cyc(5);
    // R7 reset state
    check(lockN == 1 && outEn == 0, "R7 pd lock/outEn", int'({lockN, outEn}), 2);
    check(pllHold == 1 && pllSelBak == 0 && pllRatioLog2 == 0, "R7 pd hold/sel/ratio",
          int'({pllHold, pllSelBak, pllRatioLog2}), 32);

    // R1 R2 R5 sweep of bands and modes
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 6; b++) begin
        pdN = 0; cyc(3);
        modeHigh = m[0]; ratePri = NOMC << b; rateBak = 0;
        cyc(2); pdN = 1;
        waitLock(6000, got);
        check(got, $sformatf("R5 lock mode%0d band%0d", m, b), int'(got), 1);
        check(ratioNow() == expRatio(m[0], b), $sformatf("R2 ratio mode%0d band%0d", m, b),
              ratioNow(), expRatio(m[0], b));
        check(pllSelBak == 0 && outEn == 1, "R1 primary selected", int'(pllSelBak), 0);
      end
    end

    // failover scenario, mode low: primary band3, backup band1
    pdN = 0; cyc(3); modeHigh = 0; ratePri = 96; rateBak = 24; cyc(2); pdN = 1;
    waitLock(6000, got);
    check(got, "R5 initial lock", int'(got), 1);
    ratePri = 0;
    cyc(GATE - 20);
    check(pllSelBak == 0 && pllHold == 0, "R9 no fail after one window",
          int'({pllSelBak, pllHold}), 0);
    waitSel(1'b1, 4000, got);
    check(got, "R4 switched to backup", int'(pllSelBak), 1);
    check(ratioNow() == 2, "R4 backup ratio", ratioNow(), 2);
    check(lockN == 1, "R4 lock high on backup", int'(lockN), 1);

    // return of primary
    ratePri = 96;
    cyc(3 * GATE);
    check(pllSelBak == 1, "R9 no early requalify", int'(pllSelBak), 1);
    waitLock(6000, got);
    check(got && pllSelBak == 0, "R5 back on primary", int'(pllSelBak), 0);
    check(ratioNow() == 0, "R5 primary ratio", ratioNow(), 0);

    // drift inside band3: nominal 96, tolerance 8
    ratePri = 106;
    cyc(3 * GATE);
    check(lockN == 1 && pllSelBak == 0, "R6 drift raises lock", int'({lockN, pllSelBak}), 2);
    ratePri = 96;
    waitLock(3 * GATE, got);
    check(got, "R6 lock returns", int'(got), 1);

    // count in gap between band2 and band3
    ratePri = 65;
    waitSel(1'b1, 4000, got);
    check(got, "R1 gap count invalid", int'(pllSelBak), 1);
    ratePri = 96;
    waitLock(6000, got);
    check(got, "R5 relock after gap", int'(got), 1);

    // both invalid: backup first, then primary
    rateBak = 0;
    cyc(3 * GATE);
    check(lockN == 0, "R3 backup loss keeps lock", int'(lockN), 0);
    ratePri = 0;
    cyc(4 * GATE);
    check(pllHold == 1 && lockN == 1, "R11 holdover", int'({pllHold, lockN}), 3);
    check(ratioNow() == 0, "R11 ratio kept", ratioNow(), 0);
    rateBak = 24;
    waitSel(1'b1, 5000, got);
    check(got && ratioNow() == 2, "R11 first qualified taken", ratioNow(), 2);

    // mode change restart
    ratePri = 96;
    waitLock(6000, got);
    check(got, "R5 lock before mode flip", int'(got), 1);
    modeHigh = 1;
    cyc(3);
    check(lockN == 1, "R8 lock high after mode flip", int'(lockN), 1);
    waitLock(6000, got);
    check(got && ratioNow() == 2, "R8 new mode ratio", ratioNow(), 2);

    // power-down while locked
    pdN = 0;
    cyc(2);
    check(lockN == 1 && outEn == 0 && pllHold == 1, "R7 power-down",
          int'({lockN, outEn, pllHold}), 5);
    check(pllSelBak == 0 && pllRatioLog2 == 0, "R7 pd clears select/ratio",
          int'(pllRatioLog2), 0);

    done = 1;
    summary();
  end
endmodule